// File: doc/BRIEF.md
# Function Power-State Control Register

This block holds the power-management control and status word of one peripheral function in configuration space. It keeps three things: a wake-event status flag, a wake enable and a two-bit device power state. Function logic reports wake events on one input. The block drives four outputs: an internal wake request, an enable for accesses to the function's memory range, an interrupt mask and a warm-reset pulse for the rest of the function.

Software reaches the register through a simple configuration interface made of address, per-byte enables, write data, write strobe and combinational read data. Only the fully-on state (D0) and the D3-hot state can be entered. A write that asks for either of the two intermediate codes completes normally but leaves the state as it was. The wake bits sit in an always-on reset domain with their own auxiliary reset, so a core reset and the warm reset both leave them alone.

Top module: `pmcr_top`

## Requirements
- R1: After both resets, a read at offset 54h returns 0000h, memAccessEn is 1, intMask is 0, wakeReq is 0 and warmResetPulse is 0.
- R2: A cycle with wakeEvent high sets the wake status flag (bit 15) at the next clock edge, whatever the value of the wake enable.
- R3: A write with byte enable 1 high and data bit 15 set clears the status flag. Writing 0 to bit 15 has no effect. If a wake event arrives in the same cycle as the clear, the flag stays set.
- R4: Bit 8 is a read/write wake enable. wakeReq is 1 exactly while the status flag and the enable are both 1.
- R5: Bits 1:0 hold the power state, with 00 meaning D0 and 11 meaning D3 hot. A write of 01 or 10 leaves the state unchanged.
- R6: memAccessEn is 0 while the state is D3 hot and 1 otherwise.
- R7: intMask is 1 whenever the state is not D0.
- R8: A write that changes the state from D3 hot to D0 makes warmResetPulse high for exactly one cycle, the cycle after the write. Writes that keep D0, keep D3 or move from D0 to D3 produce no pulse. The pulse does not change bits 15 and 8.
- R9: The core reset returns the state to D0 and leaves bits 15 and 8 unchanged. The auxiliary reset clears bits 15 and 8.
- R10: Bits 14:9 and 7:2 always read as 0. Reads at any other offset return 0, and writes to any other offset change nothing.
- R11: Byte enable 0 gates bits 7:0 and byte enable 1 gates bits 15:8. A write with a byte enable low leaves that byte's bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstCoreN | input | 1 | Main core reset, active low, asynchronous |
| rstAuxN | input | 1 | Always-on auxiliary reset, active low, asynchronous |
| cfgAddr | input | 8 | Configuration byte offset |
| cfgByteEn | input | 2 | Byte enables for the write |
| cfgWrEn | input | 1 | Write strobe |
| cfgWrData | input | 16 | Write data |
| cfgRdData | output | 16 | Read data (combinational) |
| wakeEvent | input | 1 | Wake condition from the function |
| wakeReq | output | 1 | Internal wake request |
| memAccessEn | output | 1 | Memory-range accesses allowed |
| intMask | output | 1 | Function interrupt held off |
| warmResetPulse | output | 1 | One-cycle warm reset of the function |

## Verification
The bench raises a wake event in the same cycle that software clears the flag. A design that gives the clear priority loses that event and reads bit 15 as 0. It writes the reserved state codes and writes with one byte enable low. A design that stores those values, or writes a byte whose enable is low, shows the change on the next read. It checks the warm pulse in the cycle after a D3-to-D0 write and again one cycle later, and also checks D0-to-D0 and D0-to-D3 writes. A pulse that is late, lasts two cycles or fires on the wrong transition is therefore reported. Separate core and auxiliary resets confirm which bits each one clears, so wake bits placed in the wrong reset domain read back wrong.

// File: rtl/pmcr_pkg.sv
package pmcr_pkg;
  localparam logic [1:0] PS_D0 = 2'b00;
  localparam logic [1:0] PS_D3 = 2'b11;
  localparam int WAKE_STS_BIT = 15;
  localparam int WAKE_EN_BIT  = 8;

  typedef struct packed {
    logic       clrWake;
    logic       ldWakeEn;
    logic       wakeEnVal;
    logic       ldPwr;
    logic [1:0] pwrVal;
  } pmStrobe_t;
endpackage

// File: rtl/pmcr_ctrl.sv
module pmcr_ctrl
  import pmcr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h54,
  localparam int BE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstCoreN,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [BE_W-1:0]   cfgByteEn,
  input  logic              cfgWrEn,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic [1:0]        curPwr,
  output logic              regHit,
  output pmStrobe_t         strb,
  output logic              warmPulse
);
  logic wrHit;
  logic pwrLegal;

  assign regHit   = (cfgAddr == REG_OFFSET);
  assign wrHit    = cfgWrEn && regHit;
  assign pwrLegal = (cfgWrData[1:0] == PS_D0) || (cfgWrData[1:0] == PS_D3);

  always_comb begin
    strb           = '0;
    strb.ldPwr     = wrHit && cfgByteEn[0] && pwrLegal;
    strb.pwrVal    = cfgWrData[1:0];
    strb.ldWakeEn  = wrHit && cfgByteEn[1];
    strb.wakeEnVal = cfgWrData[WAKE_EN_BIT];
    strb.clrWake   = wrHit && cfgByteEn[1] && cfgWrData[WAKE_STS_BIT];
  end

  always_ff @(posedge clk or negedge rstCoreN) begin
    if (!rstCoreN) warmPulse <= 1'b0;
    else           warmPulse <= strb.ldPwr && (curPwr == PS_D3) && (strb.pwrVal == PS_D0);
  end

  // R8: the pulse lasts one cycle
  p_warm_single_r8: assert property (@(posedge clk) disable iff (!rstCoreN)
    warmPulse |=> !warmPulse);
  // R8: the pulse only follows a D3-to-D0 change
  p_warm_cause_r8: assert property (@(posedge clk) disable iff (!rstCoreN)
    warmPulse |-> ($past(curPwr) == PS_D3) && (curPwr == PS_D0));
endmodule

// File: rtl/pmcr_dp.sv
module pmcr_dp
  import pmcr_pkg::*;
(
  input  logic       clk,
  input  logic       rstCoreN,
  input  logic       rstAuxN,
  input  pmStrobe_t  strb,
  input  logic       wakeEvent,
  output logic       wakeSts,
  output logic       wakeEn,
  output logic [1:0] pwrState
);
  // always-on domain
  always_ff @(posedge clk or negedge rstAuxN) begin
    if (!rstAuxN) begin
      wakeSts <= 1'b0;
      wakeEn  <= 1'b0;
    end else begin
      if (wakeEvent)         wakeSts <= 1'b1;
      else if (strb.clrWake) wakeSts <= 1'b0;
      if (strb.ldWakeEn)     wakeEn  <= strb.wakeEnVal;
    end
  end

  // core domain
  always_ff @(posedge clk or negedge rstCoreN) begin
    if (!rstCoreN)       pwrState <= PS_D0;
    else if (strb.ldPwr) pwrState <= strb.pwrVal;
  end

  // R2: an event always sets the flag
  p_wake_set_r2: assert property (@(posedge clk) disable iff (!rstAuxN)
    wakeEvent |=> wakeSts);
  // R3: a clear with no competing event empties the flag
  p_wake_clr_r3: assert property (@(posedge clk) disable iff (!rstAuxN)
    (strb.clrWake && !wakeEvent) |=> !wakeSts);
  // R5: reserved codes never enter the state
  p_no_reserved_r5: assert property (@(posedge clk) disable iff (!rstCoreN)
    (pwrState == PS_D0) || (pwrState == PS_D3));
endmodule

// File: rtl/pmcr_top.sv
module pmcr_top
  import pmcr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h54,
  localparam int BE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstCoreN,
  input  logic              rstAuxN,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [BE_W-1:0]   cfgByteEn,
  input  logic              cfgWrEn,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic [DATA_W-1:0] cfgRdData,
  input  logic              wakeEvent,
  output logic              wakeReq,
  output logic              memAccessEn,
  output logic              intMask,
  output logic              warmResetPulse
);
  pmStrobe_t  strb;
  logic       regHit;
  logic       wakeSts;
  logic       wakeEn;
  logic [1:0] pwrState;

  pmcr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET)) uCtrl (
    .clk(clk), .rstCoreN(rstCoreN), .cfgAddr(cfgAddr), .cfgByteEn(cfgByteEn),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .curPwr(pwrState),
    .regHit(regHit), .strb(strb), .warmPulse(warmResetPulse)
  );

  pmcr_dp uDp (
    .clk(clk), .rstCoreN(rstCoreN), .rstAuxN(rstAuxN), .strb(strb),
    .wakeEvent(wakeEvent), .wakeSts(wakeSts), .wakeEn(wakeEn), .pwrState(pwrState)
  );

  always_comb begin
    cfgRdData = '0;
    if (regHit) begin
      cfgRdData[WAKE_STS_BIT] = wakeSts;
      cfgRdData[WAKE_EN_BIT]  = wakeEn;
      cfgRdData[1:0]          = pwrState;
    end
  end

  assign wakeReq     = wakeSts && wakeEn;
  assign memAccessEn = (pwrState != PS_D3);
  assign intMask     = (pwrState != PS_D0);

  // R11: a write with the upper byte disabled keeps the wake enable
  p_be_keeps_wake_r11: assert property (@(posedge clk) disable iff (!rstAuxN)
    (cfgWrEn && !cfgByteEn[1]) |=> $stable(wakeEn));
  // R11: a write with the lower byte disabled keeps the power state
  p_be_keeps_pwr_r11: assert property (@(posedge clk) disable iff (!rstCoreN)
    (cfgWrEn && !cfgByteEn[0]) |=> $stable(pwrState));
endmodule

// File: tb/tb_pmcr_top.sv
module tb_pmcr_top;
  logic        clk = 0;
  logic        rstCoreN = 0, rstAuxN = 0;
  logic [7:0]  cfgAddr = 8'h54;
  logic [1:0]  cfgByteEn = 0;
  logic        cfgWrEn = 0;
  logic [15:0] cfgWrData = 0;
  logic [15:0] cfgRdData;
  logic        wakeEvent = 0;
  logic        wakeReq, memAccessEn, intMask, warmResetPulse;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  pmcr_top dut (
    .clk(clk), .rstCoreN(rstCoreN), .rstAuxN(rstAuxN), .cfgAddr(cfgAddr),
    .cfgByteEn(cfgByteEn), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .wakeEvent(wakeEvent), .wakeReq(wakeReq),
    .memAccessEn(memAccessEn), .intMask(intMask), .warmResetPulse(warmResetPulse)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(logic [7:0] a, logic [1:0] be, logic [15:0] d);
    @(negedge clk);
    cfgAddr = a; cfgByteEn = be; cfgWrData = d; cfgWrEn = 1;
    @(negedge clk);
    cfgWrEn = 0; cfgAddr = 8'h54;
  endtask

  task automatic rdChk(string tag, logic [7:0] a, logic [15:0] exp);
    cfgAddr = a; #1;
    chk(tag, cfgRdData, exp);
    cfgAddr = 8'h54;
  endtask

  task automatic pulseWake();
    @(negedge clk); wakeEvent = 1;
    @(negedge clk); wakeEvent = 0;
  endtask

  task automatic testReset();
    rdChk("R1 reset value", 8'h54, 16'h0000);
    chk("R1 memAccessEn", memAccessEn, 1);
    chk("R1 intMask", intMask, 0);
    chk("R1 wakeReq", wakeReq, 0);
    chk("R1 warmResetPulse", warmResetPulse, 0);
  endtask

  task automatic testWakeStatus();
    pulseWake();
    rdChk("R2 event sets status with enable 0", 8'h54, 16'h8000);
    chk("R4 no request while disabled", wakeReq, 0);
    cfgWrite(8'h54, 2'b11, 16'h0000);
    rdChk("R3 writing 0 keeps status", 8'h54, 16'h8000);
    cfgWrite(8'h54, 2'b01, 16'h8000);
    rdChk("R11 upper byte disabled keeps status", 8'h54, 16'h8000);
    cfgWrite(8'h54, 2'b10, 16'h8000);
    rdChk("R3 writing 1 clears status", 8'h54, 16'h0000);
    @(negedge clk);
    cfgAddr = 8'h54; cfgByteEn = 2'b10; cfgWrData = 16'h8000; cfgWrEn = 1; wakeEvent = 1;
    @(negedge clk);
    cfgWrEn = 0; wakeEvent = 0;
    rdChk("R3 event beats clear", 8'h54, 16'h8000);
    cfgWrite(8'h54, 2'b10, 16'h8000);
  endtask

  task automatic testWakeEnable();
    cfgWrite(8'h54, 2'b10, 16'h0100);
    rdChk("R4 enable reads back", 8'h54, 16'h0100);
    chk("R4 no request without status", wakeReq, 0);
    pulseWake();
    chk("R4 request with status and enable", wakeReq, 1);
    cfgWrite(8'h54, 2'b10, 16'h8100);
    chk("R4 request drops after clear", wakeReq, 0);
    rdChk("R4 enable kept after clear", 8'h54, 16'h0100);
  endtask

  task automatic testPowerStates();
    cfgWrite(8'h54, 2'b01, 16'h0003);
    rdChk("R5 enter D3", 8'h54, 16'h0103);
    chk("R6 memory refused in D3", memAccessEn, 0);
    chk("R7 interrupts masked in D3", intMask, 1);
    chk("R8 no pulse on D0 to D3", warmResetPulse, 0);
    cfgWrite(8'h54, 2'b01, 16'h0001);
    rdChk("R5 code 01 dropped", 8'h54, 16'h0103);
    cfgWrite(8'h54, 2'b01, 16'h0002);
    rdChk("R5 code 10 dropped", 8'h54, 16'h0103);
    chk("R8 no pulse on dropped write", warmResetPulse, 0);
    cfgWrite(8'h54, 2'b10, 16'h0000);
    rdChk("R11 lower byte disabled keeps state", 8'h54, 16'h0003);
    cfgWrite(8'h54, 2'b10, 16'h0100);
    cfgWrite(8'h54, 2'b01, 16'h0000);
    chk("R8 pulse in cycle after D3 to D0", warmResetPulse, 1);
    rdChk("R8 wake enable kept through warm reset", 8'h54, 16'h0100);
    chk("R6 memory allowed in D0", memAccessEn, 1);
    chk("R7 interrupts unmasked in D0", intMask, 0);
    @(negedge clk);
    chk("R8 pulse lasts one cycle", warmResetPulse, 0);
    cfgWrite(8'h54, 2'b01, 16'h0000);
    chk("R8 no pulse on D0 to D0", warmResetPulse, 0);
  endtask

  task automatic testReadZero();
    cfgWrite(8'h54, 2'b11, 16'hFFFF);
    rdChk("R10 reserved bits read 0", 8'h54, 16'h0103);
    cfgWrite(8'h58, 2'b11, 16'h0000);
    rdChk("R10 other offset write ignored", 8'h54, 16'h0103);
    rdChk("R10 other offset reads 0", 8'h58, 16'h0000);
  endtask

  task automatic testResets();
    pulseWake();
    rdChk("R9 setup", 8'h54, 16'h8103);
    @(negedge clk); rstCoreN = 0;
    @(negedge clk); @(negedge clk); rstCoreN = 1;
    @(negedge clk);
    rdChk("R9 core reset keeps wake bits", 8'h54, 16'h8100);
    chk("R9 memAccessEn after core reset", memAccessEn, 1);
    @(negedge clk); rstAuxN = 0;
    @(negedge clk); rstAuxN = 1;
    @(negedge clk);
    rdChk("R9 aux reset clears wake bits", 8'h54, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstCoreN = 1; rstAuxN = 1;
    @(negedge clk);
    testReset();
    testWakeStatus();
    testWakeEnable();
    testPowerStates();
    testReadZero();
    testResets();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule